// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block acts as the target side of a two-wire serial bus and behaves like a small byte-wide EEPROM of 128 locations. A fast system clock oversamples the already-synchronized clock line and the data line. The block pulls the data line low through an output enable and never drives it high. It recognises bus framing, checks the control byte against a fixed device-select value, takes a word address, and serves writes and reads against an internal array.

Incoming write data is collected in a ring of `PAGE` bytes. When more bytes arrive than the ring holds, the oldest are overwritten, so only the most recent `PAGE` bytes survive. A valid Stop commits them to the array over a timed programming window. During that window the block answers nothing. A write-protect input suppresses the commit and leaves the array untouched. Reads start at an internal pointer that advances after each byte. With a repeated Start they can follow an address-setting write header, which gives a random read.

Top module: `ser_eeprom_tgt`

## Requirements
- R1: A falling data line while the clock line stays high is a Start, and a rising one is a Stop. A Start in the middle of a byte abandons that byte and begins a fresh control-byte reception.
- R2: The control byte is acknowledged only if bits 7..4 equal 1010 and bits 3..1 equal `DEV_SEL`. Bit 0 is 1 for a read and 0 for a write. On a mismatch the block stays silent until the next Start.
- R3: The enable that pulls the data line low is only asserted while the clock line is low. Read data is sent most significant bit first, one bit per clock pulse, and the line is released after reset.
- R4: Each accepted byte is acknowledged by holding the data line low for the whole high phase of the ninth clock. The line is released on the falling edge that follows.
- R5: The byte after a write-mode control byte sets the pointer from its low 7 bits. Bit 7 is ignored.
- R6: A write of n data bytes (1 to 16) at address A places them at A, A+1, ... modulo 128 once the Stop is seen. The pointer then equals A+n modulo 128.
- R7: When more than 16 data bytes are sent, only the last 16 are stored, at A through A+15 modulo 128.
- R8: After a committing Stop the block is busy for exactly `PROG_CYCLES` clocks. While busy it acknowledges nothing, including its own control byte.
- R9: A Stop that follows no complete data byte writes nothing and starts no busy period.
- R10: While write protect is high, address and data bytes are still acknowledged, but the Stop starts no busy period and the array is unchanged.
- R11: Reads return the byte at the pointer and advance it by one, wrapping from 127 to 0. A read-mode control byte straight after a Start reads from the current pointer.
- R12: A write header with an address, followed by a repeated Start and a read-mode control byte, reads from that address.
- R13: When the host does not acknowledge a read byte, the block releases the data line and stays released until the next Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| wp_i | input | 1 | Write protect; high blocks commits to the array |
| sda_oe | output | 1 | High pulls the data line low |

## Verification
The collision that matters is a host addressing the block while a programming window is still counting. The acknowledge path and the busy timer then act on the same control byte. The bench sends a control byte straight after a committing Stop, while the window is far from expiry, and expects silence. It sends the same byte again after the window and expects an acknowledge. A second collision happens when the ring wraps while bytes are still arriving. This is provoked with a 20-byte write, and the bench judges the outcome by reading back the neighbouring addresses as well as the stored bytes.

// File: rtl/ser_eeprom_tgt.sv
module ser_eeprom_tgt #(
  parameter int ADDR_W = 7,
  parameter int PAGE = 16,
  parameter int PROG_CYCLES = 250000,
  parameter logic [2:0] DEV_SEL = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(PAGE + 1);
  localparam int PCW = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {P_IDLE, P_RX, P_ACK, P_TX, P_RACK, P_IGN} phase_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA} kind_t;

  phase_t ph;
  kind_t kind;
  logic scl_q, sda_q;
  logic [3:0] bits;
  logic [7:0] sh, tx;
  logic rd, hack, busy;
  logic [ADDR_W-1:0] ptr, wa, paddr;
  logic [PW-1:0] wi, pbase;
  logic [CW-1:0] fill, plen;
  logic [PCW-1:0] pc;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  logic scl_rise, scl_fall, start_c, stop_c, take_data, prog_we;
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c = scl_i & scl_q & ~sda_q & sda_i;
  assign take_data = (ph == P_RX) && scl_fall && (bits == 4'd8) && (kind == K_DATA);
  assign prog_we = busy && (pc < PCW'(plen));

  always_ff @(posedge clk) begin
    if (take_data) pbuf[wi] <= sh;
    if (prog_we) mem[paddr + ADDR_W'(pc)] <= pbuf[pbase + PW'(pc)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      ph <= P_IDLE;
      kind <= K_CTRL;
      bits <= '0;
      sh <= '0;
      tx <= '0;
      rd <= 1'b0;
      hack <= 1'b0;
      busy <= 1'b0;
      ptr <= '0;
      wa <= '0;
      paddr <= '0;
      wi <= '0;
      pbase <= '0;
      fill <= '0;
      plen <= '0;
      pc <= '0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (busy) begin
        pc <= pc + 1'b1;
        if (pc == PCW'(PROG_CYCLES - 1)) busy <= 1'b0;
      end
      if (start_c) begin
        ph <= P_RX;
        kind <= K_CTRL;
        bits <= '0;
        fill <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        ph <= P_IDLE;
        sda_oe <= 1'b0;
        fill <= '0;
        if (fill != '0 && !wp_i && !busy) begin
          busy <= 1'b1;
          pc <= '0;
          plen <= fill;
          pbase <= wi - PW'(fill);
          paddr <= wa;
          ptr <= wa + ADDR_W'(fill);
        end
      end else begin
        case (ph)
          P_RX:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_i};
              bits <= bits + 1'b1;
            end else if (scl_fall && bits == 4'd8) begin
              bits <= '0;
              case (kind)
                K_CTRL:
                  if (sh[7:4] == 4'b1010 && sh[3:1] == DEV_SEL && !busy) begin
                    sda_oe <= 1'b1;
                    ph <= P_ACK;
                    rd <= sh[0];
                    kind <= K_ADDR;
                  end else begin
                    ph <= P_IGN;
                  end
                K_ADDR: begin
                  sda_oe <= 1'b1;
                  ph <= P_ACK;
                  ptr <= sh[ADDR_W-1:0];
                  wa <= sh[ADDR_W-1:0];
                  kind <= K_DATA;
                end
                default: begin
                  sda_oe <= 1'b1;
                  ph <= P_ACK;
                  wi <= wi + 1'b1;
                  if (fill != CW'(PAGE)) fill <= fill + 1'b1;
                end
              endcase
            end
          P_ACK:
            if (scl_fall) begin
              if (rd) begin
                tx <= mem[ptr];
                sda_oe <= ~mem[ptr][7];
                ptr <= ptr + 1'b1;
                bits <= '0;
                ph <= P_TX;
              end else begin
                sda_oe <= 1'b0;
                ph <= P_RX;
              end
            end
          P_TX:
            if (scl_rise) begin
              bits <= bits + 1'b1;
            end else if (scl_fall) begin
              if (bits == 4'd8) begin
                sda_oe <= 1'b0;
                ph <= P_RACK;
              end else begin
                sda_oe <= ~tx[3'd7 - bits[2:0]];
              end
            end
          P_RACK:
            if (scl_rise) begin
              hack <= ~sda_i;
            end else if (scl_fall) begin
              if (hack) begin
                tx <= mem[ptr];
                sda_oe <= ~mem[ptr][7];
                ptr <= ptr + 1'b1;
                bits <= '0;
                ph <= P_TX;
              end else begin
                ph <= P_IGN;
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module ser_eeprom_tgt_chk #(
  parameter int PROG_CYCLES = 250000
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic wp_i,
  input logic busy
);
  logic [31:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else bcnt <= '0;
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i); // R3
  AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe)); // R4
  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R8
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == PROG_CYCLES); // R8
  AST_WP_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp_i)); // R10
endmodule

bind ser_eeprom_tgt ser_eeprom_tgt_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wp_i(wp_i), .busy(busy)
);

// File: tb/ser_eeprom_tgt_tb.sv
module ser_eeprom_tgt_tb;
  localparam int P = 300;
  localparam logic [2:0] DS = 3'b010;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, hsda = 1'b1, wp = 1'b0;
  logic sda_oe, sda_line;
  int checks = 0, fails = 0;
  logic [7:0] expm [128];
  logic [7:0] wd [32];

  assign sda_line = hsda & ~sda_oe;
  always #10 clk = ~clk;

  ser_eeprom_tgt #(.PROG_CYCLES(P), .DEV_SEL(DS)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic q(input int n = 1);
    repeat (5 * n) @(negedge clk);
  endtask

  task automatic st();
    hsda = 1'b1; q(); scl = 1'b1; q(); hsda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic sp();
    hsda = 1'b0; q(); scl = 1'b1; q(); hsda = 1'b1; q();
  endtask

  task automatic clk_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hsda = b[i]; q(); scl = 1'b1; q(2); scl = 1'b0; q();
    end
  endtask

  task automatic tx(input logic [7:0] b, output bit ack);
    bit a1, a2;
    clk_bits(b, 8);
    hsda = 1'b1; q(); scl = 1'b1;
    repeat (2) @(negedge clk);
    a1 = !sda_line;
    repeat (7) @(negedge clk);
    a2 = !sda_line;
    @(negedge clk);
    scl = 1'b0; q();
    ack = a1 && a2;
  endtask

  task automatic rxb(input bit ack, output logic [7:0] b);
    hsda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl = 1'b1; q(); b[i] = sda_line; q(); scl = 1'b0;
    end
    q(); hsda = !ack; q(); scl = 1'b1; q(2); scl = 1'b0; q(); hsda = 1'b1;
  endtask

  task automatic wr(input int a, input int n, output int nacks);
    bit k;
    nacks = 0;
    st();
    tx({4'hA, DS, 1'b0}, k); nacks += int'(!k);
    tx(8'(a), k); nacks += int'(!k);
    for (int i = 0; i < n; i++) begin
      tx(wd[i], k); nacks += int'(!k);
    end
    sp();
    if (!wp) begin
      for (int i = 0; i < n; i++)
        if (i >= n - 16) expm[(a + i - ((n > 16) ? n - 16 : 0)) % 128] = wd[i];
    end
  endtask

  task automatic rd_rand(input int a, input int n, input string tag);
    bit k;
    logic [7:0] b;
    st();
    tx({4'hA, DS, 1'b0}, k);
    tx(8'(a), k);
    st();
    tx({4'hA, DS, 1'b1}, k);
    chk(k, {tag, " read ctrl ack"}, int'(k), 1);
    for (int i = 0; i < n; i++) begin
      rxb(i != n - 1, b);
      chk(b == expm[(a + i) % 128], tag, int'(b), int'(expm[(a + i) % 128]));
    end
    q(2);
    chk(sda_line == 1'b1, "R13 released after host nack", int'(sda_line), 1);
    sp();
  endtask

  task automatic ctrl_probe(input logic [7:0] c, output bit k);
    st(); tx(c, k); sp();
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit k;
    int nk;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    q(2);
    chk(sda_oe == 1'b0, "R3 line released after reset", int'(sda_oe), 0);

    for (int s = 0; s < 8; s++) begin
      ctrl_probe({4'hA, 3'(s), 1'b0}, k);
      chk(k == (3'(s) == DS), "R2 device select sweep", int'(k), int'(3'(s) == DS));
    end
    ctrl_probe({4'hB, DS, 1'b0}, k);
    chk(!k, "R2 wrong prefix", int'(k), 0);
    ctrl_probe({4'hA, DS, 1'b0}, k);
    chk(k, "R9 no busy after empty write", int'(k), 1);

    for (int pg = 0; pg < 8; pg++) begin
      for (int i = 0; i < 16; i++) wd[i] = 8'((pg * 16 + i) * 37 + 5);
      wr(pg * 16, 16, nk);
      chk(nk == 0, "R4 page write acks", nk, 0);
      if (pg == 0) begin
        ctrl_probe({4'hA, DS, 1'b0}, k);
        chk(!k, "R8 silent while programming", int'(k), 0);
      end
      q(P / 5 + 20);
    end
    ctrl_probe({4'hA, DS, 1'b0}, k);
    chk(k, "R8 acks after programming window", int'(k), 1);

    rd_rand(0, 130, "R11 R12 full sweep with wrap");

    for (int i = 0; i < 20; i++) wd[i] = 8'(8'hA0 + i);
    wr(100, 20, nk);
    chk(nk == 0, "R7 overflow write acks", nk, 0);
    q(P / 5 + 20);
    st(); tx({4'hA, DS, 1'b1}, k); rxb(1'b0, b); sp();
    chk(b == expm[116], "R6 pointer after write", int'(b), int'(expm[116]));
    rd_rand(99, 18, "R7 last sixteen kept");

    for (int i = 0; i < 3; i++) wd[i] = 8'(8'h70 + i);
    wr(126, 3, nk);
    q(P / 5 + 20);
    rd_rand(126, 4, "R6 write wraps at top");

    wp = 1'b1;
    for (int i = 0; i < 4; i++) wd[i] = 8'h55;
    wr(10, 4, nk);
    chk(nk == 0, "R10 acks under protect", nk, 0);
    ctrl_probe({4'hA, DS, 1'b0}, k);
    chk(k, "R10 no busy under protect", int'(k), 1);
    wp = 1'b0;
    rd_rand(10, 4, "R10 array unchanged");

    st(); tx({4'hA, DS, 1'b0}, k); tx(8'd20, k);
    clk_bits(8'hF0, 4);
    sp();
    ctrl_probe({4'hA, DS, 1'b0}, k);
    chk(k, "R9 partial byte no busy", int'(k), 1);
    rd_rand(20, 1, "R9 partial byte not written");

    st(); tx({4'hA, DS, 1'b0}, k); tx(8'd40, k);
    clk_bits(8'h00, 3);
    st();
    tx({4'hA, DS, 1'b1}, k);
    chk(k, "R1 repeated start mid byte", int'(k), 1);
    rxb(1'b0, b);
    sp();
    chk(b == expm[40], "R1 aborted byte discarded", int'(b), int'(expm[40]));

    rd_rand(128 + 5, 1, "R5 address bit7 ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule